// File: doc/BRIEF.md
# Programmable DRAM Bank Address Decoder

This block keeps the configuration of two DRAM banks and, for every bus cycle, decides combinationally whether the cycle falls into one of them. A bank is described by a base address for the upper fifteen address bits, a count of how many of those bits must match, read and write permissions, and a permission bit for each of the four function codes that may reach memory. Configuration is held in two 16-bit half-words per bank. Software writes them through a small register port that accepts only supervisor writes, and can read them back.

A bus master presents address, function code, direction and a valid strobe. The block answers with one hit line per bank. Illegal settings keep a bank quiet: a base bit set outside the compared range, both directions disabled, or all function codes disabled. When two banks claim the same cycle, the lower-numbered bank wins. Timing generation, refresh and row/column handling lie outside this block.

Top module: `dram_bank_decoder`

## Requirements
- R1: With match count N (low half-word bits 7:4), address bits A31 down to A(32-N) must equal the stored base bits for the same positions. N=0 compares none, N=1 compares only A31, and N=15 compares A31..A17. Address bits below A17 never take part.
- R2: If any stored base bit outside the compared range is 1, the bank never hits.
- R3: A read cycle (bus_rd=1) hits a bank only if that bank's read-enable bit, low half-word bit 15, is 1.
- R4: A write cycle (bus_rd=0) hits a bank only if that bank's write-enable bit, high half-word bit 0, is 1.
- R5: The function-code enables sit in the low half-word: bit 14 for code 6, bit 13 for code 5, bit 10 for code 2 and bit 9 for code 1. A cycle whose code's enable is 0 does not hit.
- R6: Function codes 0, 3, 4 and 7 never produce a hit.
- R7: bank_hit is all zero whenever bus_valid is 0.
- R8: At most one bank_hit bit is set. When several banks match, only the lowest-numbered one is reported.
- R9: A register write takes effect on the clock edge only when cfg_super=1. A write with cfg_super=0 leaves the register unchanged.
- R10: cfg_rdata returns the half-word selected by cfg_bank and cfg_half (0=low, 1=high) exactly as written, including the untouched bits 3:0 and bits 12, 11 and 8 of the low half. The high half-word holds base bits A31..A17 in bits 15:1.
- R11: Reset clears all configuration to zero, so every register reads 0 and no bank hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_super | input | 1 | Write comes from a supervisor access |
| cfg_bank | input | SELW | Bank selected for write and readback |
| cfg_half | input | 1 | Half-word select, 0 low, 1 high |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Readback of the selected half-word |
| bus_valid | input | 1 | Bus cycle valid |
| bus_rd | input | 1 | 1 for read, 0 for write |
| bus_fc | input | 3 | Function code of the cycle |
| bus_addr | input | AW | Cycle address |
| bank_hit | output | NBANK | One-hot-or-zero bank hit |

## Verification
The hardest case to reach from the ports is two banks that both accept the same cycle, because the priority rule only shows up then. The stimulus first programs bank 1 with a zero match count, zero base and every permission enabled, so it matches the whole address space. Cycles aimed inside bank 0's window must then report only bank 0, and cycles outside it must fall through to bank 1. The same bank is then reprogrammed with a nonzero base under a zero match count, to show that a stray base bit blocks it completely.

// File: rtl/dram_bank_decoder.sv
module dram_bank_decoder #(
  parameter int NBANK = 2,
  parameter int AW    = 32,
  localparam int SELW = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int MB   = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_super,
  input  logic [SELW-1:0]  cfg_bank,
  input  logic             cfg_half,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  input  logic             bus_valid,
  input  logic             bus_rd,
  input  logic [2:0]       bus_fc,
  input  logic [AW-1:0]    bus_addr,
  output logic [NBANK-1:0] bank_hit
);

  logic [NBANK-1:0][15:0] lo_q, hi_q;
  logic [NBANK-1:0]       raw;
  logic [NBANK:0]         taken;
  logic [MB-1:0]          abits;

  assign abits = bus_addr[AW-1 -: MB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (cfg_we && cfg_super && (int'(cfg_bank) < NBANK)) begin
      if (cfg_half) hi_q[cfg_bank] <= cfg_wdata;
      else          lo_q[cfg_bank] <= cfg_wdata;
    end
  end

  assign cfg_rdata = cfg_half ? hi_q[cfg_bank] : lo_q[cfg_bank];

  function automatic logic fc_allowed(input logic [15:0] lo, input logic [2:0] fc);
    case (fc)
      3'd6:    return lo[14];
      3'd5:    return lo[13];
      3'd2:    return lo[10];
      3'd1:    return lo[9];
      default: return 1'b0;
    endcase
  endfunction

  assign taken[0] = 1'b0;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [3:0]    cnt;
    logic [MB-1:0] base, mask;
    logic          dir_ok, base_ok, addr_ok;

    assign cnt     = lo_q[b][7:4];
    assign base    = hi_q[b][15:1];
    assign mask    = ~({MB{1'b1}} >> cnt);
    assign dir_ok  = bus_rd ? lo_q[b][15] : hi_q[b][0];
    assign base_ok = (base & ~mask) == '0;
    assign addr_ok = ((abits ^ base) & mask) == '0;

    assign raw[b]      = bus_valid & dir_ok & base_ok & addr_ok & fc_allowed(lo_q[b], bus_fc);
    assign taken[b+1]  = taken[b] | raw[b];
    assign bank_hit[b] = raw[b] & ~taken[b];
  end

endmodule

// File: rtl/dram_bank_decoder_chk.sv
module dram_bank_decoder_chk #(
  parameter int NBANK = 2,
  parameter int SELW  = 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_we,
  input logic                   cfg_super,
  input logic [SELW-1:0]        cfg_bank,
  input logic                   cfg_half,
  input logic [15:0]            cfg_wdata,
  input logic [15:0]            cfg_rdata,
  input logic                   bus_valid,
  input logic                   bus_rd,
  input logic [2:0]             bus_fc,
  input logic [NBANK-1:0]       bank_hit,
  input logic [NBANK-1:0][15:0] lo_q,
  input logic [NBANK-1:0][15:0] hi_q
);

  p_one_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_hit));

  p_hit_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_hit) |-> bus_valid);

  p_fc_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_hit) |-> (bus_fc == 3'd1 || bus_fc == 3'd2 || bus_fc == 3'd5 || bus_fc == 3'd6));

  p_user_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_super) |=>
      (cfg_bank != $past(cfg_bank) || cfg_half != $past(cfg_half) || cfg_rdata == $past(cfg_rdata)));

  p_sup_wr_readback_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_super) |=>
      (cfg_bank != $past(cfg_bank) || cfg_half != $past(cfg_half) || cfg_rdata == $past(cfg_wdata)));

  for (genvar b = 0; b < NBANK; b++) begin : g_chk
    p_rd_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_hit[b] && bus_rd) |-> lo_q[b][15]);
    p_wr_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_hit[b] && !bus_rd) |-> hi_q[b][0]);
  end

endmodule

bind dram_bank_decoder dram_bank_decoder_chk #(.NBANK(NBANK), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_super(cfg_super),
  .cfg_bank(cfg_bank), .cfg_half(cfg_half), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .bus_valid(bus_valid), .bus_rd(bus_rd),
  .bus_fc(bus_fc), .bank_hit(bank_hit), .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/sim_dram_bank_decoder.sv
module sim_dram_bank_decoder;
  localparam int TCLK = 10;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, cfg_super = 0, cfg_half = 0;
  logic [0:0]  cfg_bank = '0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic        bus_valid = 0, bus_rd = 0;
  logic [2:0]  bus_fc = '0;
  logic [31:0] bus_addr = '0;
  logic [1:0]  bank_hit;

  dram_bank_decoder u0 (.*);

  always #(TCLK/2) clk = ~clk;

  typedef struct {
    bit          is_rd;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it  = q.pop_front();
      act = it.is_rd ? cfg_rdata : {14'd0, bank_hit};
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input bit bank, input bit half, input logic [15:0] d, input bit sup);
    @(negedge clk);
    bus_valid = 0;
    cfg_we = 1; cfg_super = sup; cfg_bank = bank; cfg_half = half; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0; cfg_super = 0;
  endtask

  task automatic rd_chk(input bit bank, input bit half, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    cfg_we = 0; cfg_bank = bank; cfg_half = half;
    it.is_rd = 1; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(posedge clk); #2;
  endtask

  task automatic cyc(input logic [31:0] a, input logic [2:0] fc, input bit rd, input bit v,
                     input logic [1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a; bus_fc = fc; bus_rd = rd; bus_valid = v;
    it.is_rd = 0; it.exp = {14'd0, e}; it.tag = tag;
    q.push_back(it);
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R11: reset state
    rd_chk(0, 0, 16'h0000, "R11 lo0");
    rd_chk(0, 1, 16'h0000, "R11 hi0");
    rd_chk(1, 0, 16'h0000, "R11 lo1");
    rd_chk(1, 1, 16'h0000, "R11 hi1");
    cyc(32'h0000_0000, 3'd1, 1, 1, 2'b00, "R11 no hit after reset");

    // bank0: read on, fc6/5/2/1, N=4, base 0x1000_0000, write on
    wr(0, 0, 16'hE640, 1);
    wr(0, 1, 16'h1001, 1);
    // bank1: read off, only fc5, N=15, extra bits 0xA, base 0x2002_0000, write on
    wr(1, 0, 16'h20FA, 1);
    wr(1, 1, 16'h2003, 1);

    rd_chk(1, 0, 16'h20FA, "R10 lo1 exact");
    rd_chk(0, 1, 16'h1001, "R10 hi0 exact");

    cyc(32'h1234_5678, 3'd5, 1, 1, 2'b01, "R1 N=4 match");
    cyc(32'h2000_0000, 3'd5, 1, 1, 2'b00, "R1 N=4 mismatch");
    cyc(32'h2002_0000, 3'd5, 0, 1, 2'b10, "R1 N=15 match");
    cyc(32'h2002_FFFF, 3'd5, 0, 1, 2'b10, "R1 low bits ignored");
    cyc(32'h2004_0000, 3'd5, 0, 1, 2'b00, "R1 A18 mismatch");
    cyc(32'h2002_0000, 3'd5, 1, 1, 2'b00, "R3 read disabled");
    cyc(32'h2002_0000, 3'd6, 0, 1, 2'b00, "R5 fc6 disabled");
    cyc(32'h1000_0000, 3'd6, 1, 1, 2'b01, "R5 fc6 enabled");
    cyc(32'h1000_0000, 3'd2, 1, 1, 2'b01, "R5 fc2 enabled");
    cyc(32'h1000_0000, 3'd1, 1, 1, 2'b01, "R5 fc1 enabled");
    for (int f = 0; f < 8; f++)
      if (f == 0 || f == 3 || f == 4 || f == 7)
        cyc(32'h1000_0000, f[2:0], 1, 1, 2'b00, "R6 other fc");
    cyc(32'h1000_0000, 3'd1, 1, 0, 2'b00, "R7 valid low");

    // R9: user write ignored
    wr(0, 0, 16'h0000, 0);
    rd_chk(0, 0, 16'hE640, "R9 user write ignored");
    cyc(32'h1000_0000, 3'd1, 1, 1, 2'b01, "R9 bank0 still hits");

    // R4: write enable
    wr(0, 1, 16'h1000, 1);
    cyc(32'h1000_0000, 3'd1, 0, 1, 2'b00, "R4 write disabled");
    cyc(32'h1000_0000, 3'd1, 1, 1, 2'b01, "R4 read still hits");
    wr(0, 1, 16'h1001, 1);

    // R8: bank1 covers everything
    wr(1, 0, 16'hE600, 1);
    wr(1, 1, 16'h0001, 1);
    cyc(32'h1000_0000, 3'd1, 1, 1, 2'b01, "R8 bank0 priority");
    cyc(32'h5000_0000, 3'd1, 1, 1, 2'b10, "R8 fall through");

    // R2: nonzero base outside range with N=0
    wr(1, 1, 16'h2003, 1);
    cyc(32'h2002_0000, 3'd5, 1, 1, 2'b00, "R2 stray base bit");
    cyc(32'h5000_0000, 3'd5, 1, 1, 2'b00, "R2 stray base anywhere");

    @(negedge clk) bus_valid = 0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule